// File: doc/BRIEF.md
# Switchable-Order Digital Jitter Attenuator

This block smooths the bit rate of a single tributary. Bits arrive in gapped bursts with a write strobe and go into a 32-entry elastic store. An output strobe comes from a 32-bit phase accumulator that runs on the system clock. The accumulator's step is a nominal value, set by the selected line rate, plus a correction word. A loop filter builds that correction from how far the store's fill sits from half depth. The result is an evenly spaced output strobe that tracks the long-term input rate.

The filter normally adds a proportional term and an integral term, which makes a second-order loop. Bandwidth and damping are set by two programmable shift amounts. When order switching is enabled, each pointer-adjustment pulse freezes the integral term for a programmed number of clock cycles. During that window the loop is first order and passes the phase step through with only the proportional term. An alarm-insert input forces the output data to ones. Store overflow and underflow are kept as sticky flags, and either event re-centres the store.

Top module: `jitter_attenuator`

## Requirements
- R1: Output bits appear in write order, one bit per `out_strobe` pulse, carried on `out_bit` in the same cycle. After reset the store holds 16 ones ahead of the first written bit. The first 16 output bits are therefore 1.
- R2: The accumulator step with zero correction is floor(rate × 2^32 / CLK_HZ). `rate_sel`=0 selects 1 544 000 b/s and `rate_sel`=1 selects 2 048 000 b/s. With no writes after reset, the first `out_strobe` is seen in cycle k, the smallest k with k × step ≥ 2^32. Two strobes are never adjacent.
- R3: `loop_corr` = P + I, where P = ((fill − 16) · 2^20) >>> `kp_shift` (arithmetic shift) and I is the integral register.
- R4: On each output strobe outside first-order mode, I grows by ((fill − 16) · 2^14) >>> `ki_shift`. The fill used is the value before that cycle's update. I is clamped to ±2^24 and is otherwise unchanged.
- R5: With `order_switch_en`=1, a `ptr_adj` pulse raises `first_order` from the next cycle for exactly `hold_len` cycles. A `hold_len` of 0 gives no first-order window.
- R6: A new `ptr_adj` pulse during a window reloads the count to `hold_len`. The window then lasts that many cycles from the new pulse.
- R7: With `order_switch_en`=0, `ptr_adj` has no effect and `first_order` stays 0.
- R8: While `first_order` is 1, the integral term I does not change.
- R9: While `ais_force` is 1, `out_bit` is 1, whatever data the store holds.
- R10: A write into a full store with no read in the same cycle sets `ovf_flag`. The bit is dropped and `fill_level` becomes 16 at that same edge.
- R11: A read from an empty store sets `unf_flag`, outputs a 1 and sets `fill_level` to 16 at that same edge.
- R12: Reset gives `fill_level`=16, `out_strobe`=0, `out_bit`=1, `loop_corr`=0, `first_order`=0 and both flags 0. The flags then stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write strobe for the gapped input |
| in_bit | input | 1 | Input data bit |
| rate_sel | input | 1 | 0: 1.544 Mb/s nominal, 1: 2.048 Mb/s nominal |
| order_switch_en | input | 1 | Allow pointer pulses to drop the loop to first order |
| ptr_adj | input | 1 | Pointer-adjustment event pulse |
| hold_len | input | 16 | First-order window length in clock cycles |
| kp_shift | input | 4 | Right shift applied to the proportional term |
| ki_shift | input | 4 | Right shift applied to the integral step |
| ais_force | input | 1 | Force output data to ones |
| out_strobe | output | 1 | Smoothed output bit strobe |
| out_bit | output | 1 | Output data bit, valid with out_strobe |
| fill_level | output | 6 | Elastic store occupancy |
| loop_corr | output | 32 | Signed correction added to the nominal step |
| first_order | output | 1 | Integral term frozen (first-order loop) |
| ovf_flag | output | 1 | Sticky store overflow |
| unf_flag | output | 1 | Sticky store underflow |

## Verification
The fill level, the first-order flag, the sticky flags and the integral register change at the clock edge after the input that causes them. The output strobe and its data bit are registered at the same edge as the accumulator carry. `loop_corr` is combinational from the fill level and the integral register, and the alarm override acts on `out_bit` with no delay. The bench drives inputs at the falling edge and samples at the next falling edge, so each result is read one edge after its cause. Window lengths are counted in falling edges with `first_order` high. The integral step is checked with the fill recorded one sample before the strobe.

// File: rtl/ja_pkg.sv
// Shared definitions for the jitter attenuator.
// Assumes a 32-bit phase accumulator and a system clock well above 4.1 MHz,
// so the nominal step stays below half of the accumulator range.
package ja_pkg;

    localparam int ACC_W = 32;

    typedef enum logic {
        RATE_1544K = 1'b0,
        RATE_2048K = 1'b1
    } line_rate_e;

    // Nominal accumulator step: line rate * 2^ACC_W / clock frequency.
    function automatic logic [ACC_W-1:0] nominal_step(input longint unsigned clk_hz,
                                                      input line_rate_e rate);
        longint unsigned bps;
        bps = (rate == RATE_2048K) ? 64'd2048000 : 64'd1544000;
        return ACC_W'((bps << ACC_W) / clk_hz);
    endfunction

endpackage

// File: rtl/ja_elastic_store.sv
// One-bit-wide elastic store with read and write pointers and a fill counter.
// Resets half full with ones in the unread half. A write into a full store
// with no read is dropped. A read from an empty store yields a 1. Both faults
// re-centre the read pointer to half depth behind the write pointer.
// Assumes DEPTH is a power of two.
module ja_elastic_store #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_bit,
    input  logic                       rd_en,
    output logic                       rd_bit,
    output logic [$clog2(DEPTH):0]     fill,
    output logic                       ovf_evt,
    output logic                       unf_evt
);
    localparam int AW   = $clog2(DEPTH);
    localparam int FW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    logic          mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [AW-1:0] wr_ptr_nx;

    // Fault detection and read data selection.
    always_comb begin
        ovf_evt   = wr_en && !rd_en && (fill == FW'(DEPTH));
        unf_evt   = rd_en && (fill == '0);
        rd_bit    = unf_evt ? 1'b1 : mem[rd_ptr_q];
        wr_ptr_nx = wr_ptr_q + AW'(wr_en && !ovf_evt);
    end

    // Storage array: reset to ones, written when not overflowing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b1;
        end else if (wr_en && !ovf_evt) begin
            mem[wr_ptr_q] <= wr_bit;
        end
    end

    // Pointer and occupancy update, with re-centring on faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= AW'(HALF);
            fill     <= FW'(HALF);
        end else begin
            wr_ptr_q <= wr_ptr_nx;
            if (ovf_evt || unf_evt) begin
                rd_ptr_q <= wr_ptr_nx - AW'(HALF);
                fill     <= FW'(HALF);
            end else begin
                rd_ptr_q <= rd_ptr_q + AW'(rd_en);
                fill     <= fill + FW'(wr_en) - FW'(rd_en);
            end
        end
    end

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH)); // R1
    AST_OVF_RECENTER: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> fill == FW'(HALF)); // R10
    AST_UNF_RECENTER: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> fill == FW'(HALF)); // R11

endmodule

// File: rtl/ja_order_ctrl.sv
// Loop-order control. When switching is enabled, a pointer-adjustment pulse
// loads a hold counter. The loop is first order while the counter is
// non-zero. A pulse during the window reloads the counter.
module ja_order_ctrl #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_evt,
    input  logic              switch_en,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              first_order
);
    logic [HOLD_W-1:0] cnt_q;

    assign first_order = (cnt_q != '0);

    // Hold counter: reload on an enabled event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ptr_evt && switch_en) begin
            cnt_q <= hold_len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_evt && switch_en) |=> cnt_q == $past(hold_len)); // R6
    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ptr_evt && switch_en) && first_order) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_en && !first_order) |=> !first_order); // R7

endmodule

// File: rtl/ja_loop_filter.sv
// Proportional-plus-integral loop filter on the store's phase error
// (fill minus half depth). Gains are power-of-two right shifts. The integral
// register moves only on output strobes, is frozen in first-order mode and is
// clamped to +/-INT_LIM.
module ja_loop_filter
    import ja_pkg::*;
#(
    parameter int FW      = 6,
    parameter int HALF    = 16,
    parameter int P_BASE  = 20,
    parameter int I_BASE  = 14,
    parameter int INT_LIM = 1 << 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FW-1:0]           fill,
    input  logic [3:0]              kp_shift,
    input  logic [3:0]              ki_shift,
    input  logic                    step_en,
    input  logic                    freeze,
    output logic signed [ACC_W-1:0] corr
);
    localparam logic signed [ACC_W-1:0] HALF_S  = ACC_W'(HALF);
    localparam logic signed [ACC_W:0]   LIM_POS = {1'b0, ACC_W'(INT_LIM)};
    localparam logic signed [ACC_W:0]   LIM_NEG = -LIM_POS;

    logic signed [ACC_W-1:0] err;
    logic signed [ACC_W-1:0] prop;
    logic signed [ACC_W-1:0] istep;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] integ_nx;
    logic signed [ACC_W:0]   isum;

    // Phase error, both gain terms and the clamped integral candidate.
    always_comb begin
        err   = $signed({{(ACC_W-FW){1'b0}}, fill}) - HALF_S;
        prop  = (err <<< P_BASE) >>> kp_shift;
        istep = (err <<< I_BASE) >>> ki_shift;
        isum  = $signed({integ_q[ACC_W-1], integ_q}) + $signed({istep[ACC_W-1], istep});
        if (isum > LIM_POS)      integ_nx = LIM_POS[ACC_W-1:0];
        else if (isum < LIM_NEG) integ_nx = LIM_NEG[ACC_W-1:0];
        else                     integ_nx = isum[ACC_W-1:0];
        corr  = prop + integ_q;
    end

    // Integral register: steps on output strobes outside first-order mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
        end else if (step_en && !freeze) begin
            integ_q <= integ_nx;
        end
    end

    AST_INTEG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(integ_q)); // R8
    AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(integ_q)); // R4
    AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed({integ_q[ACC_W-1], integ_q}) <= LIM_POS) &&
        ($signed({integ_q[ACC_W-1], integ_q}) >= LIM_NEG)); // R4

endmodule

// File: rtl/ja_nco.sv
// Numerically controlled oscillator: a phase accumulator stepped each clock
// by the nominal step for the selected rate plus a signed correction.
// The carry out is the output tick. Assumes the corrected step stays
// positive and below half the accumulator range.
module ja_nco
    import ja_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 19_440_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rate_sel,
    input  logic signed [ACC_W-1:0] corr,
    output logic                    tick
);
    localparam logic [ACC_W-1:0] STEP_LO = nominal_step(CLK_HZ, RATE_1544K);
    localparam logic [ACC_W-1:0] STEP_HI = nominal_step(CLK_HZ, RATE_2048K);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step;
    logic [ACC_W:0]   sum;

    // Corrected step and the accumulator sum with its carry.
    always_comb begin
        step = (line_rate_e'(rate_sel) == RATE_2048K ? STEP_HI : STEP_LO) + $unsigned(corr);
        sum  = {1'b0, acc_q} + {1'b0, step};
        tick = sum[ACC_W];
    end

    // Phase accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/jitter_attenuator.sv
// Single-tributary digital jitter attenuator. Gapped input bits fill an
// elastic store. An oscillator steered by a PI loop filter on the store's fill
// reads them out at a smoothed rate. Pointer events can freeze the integral
// term for a programmed time. The alarm input forces output ones.
// Overflow and underflow are sticky until reset.
module jitter_attenuator
    import ja_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 19_440_000,
    parameter int DEPTH   = 32,
    parameter int HOLD_W  = 16,
    parameter int P_BASE  = 20,
    parameter int I_BASE  = 14,
    parameter int INT_LIM = 1 << 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_bit,
    input  logic                        rate_sel,
    input  logic                        order_switch_en,
    input  logic                        ptr_adj,
    input  logic [HOLD_W-1:0]           hold_len,
    input  logic [3:0]                  kp_shift,
    input  logic [3:0]                  ki_shift,
    input  logic                        ais_force,
    output logic                        out_strobe,
    output logic                        out_bit,
    output logic [$clog2(DEPTH):0]      fill_level,
    output logic signed [ACC_W-1:0]     loop_corr,
    output logic                        first_order,
    output logic                        ovf_flag,
    output logic                        unf_flag
);
    localparam int FW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic tick;
    logic rd_bit;
    logic ovf_evt;
    logic unf_evt;
    logic data_q;

    ja_elastic_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_bit  (in_bit),
        .rd_en   (tick),
        .rd_bit  (rd_bit),
        .fill    (fill_level),
        .ovf_evt (ovf_evt),
        .unf_evt (unf_evt)
    );

    ja_order_ctrl #(.HOLD_W(HOLD_W)) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_evt     (ptr_adj),
        .switch_en   (order_switch_en),
        .hold_len    (hold_len),
        .first_order (first_order)
    );

    ja_loop_filter #(
        .FW(FW), .HALF(HALF), .P_BASE(P_BASE), .I_BASE(I_BASE), .INT_LIM(INT_LIM)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill_level),
        .kp_shift (kp_shift),
        .ki_shift (ki_shift),
        .step_en  (tick),
        .freeze   (first_order),
        .corr     (loop_corr)
    );

    ja_nco #(.CLK_HZ(CLK_HZ)) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .corr     (loop_corr),
        .tick     (tick)
    );

    // Output strobe and data register, plus sticky fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_strobe <= 1'b0;
            data_q     <= 1'b1;
            ovf_flag   <= 1'b0;
            unf_flag   <= 1'b0;
        end else begin
            out_strobe <= tick;
            if (tick) data_q <= rd_bit;
            ovf_flag   <= ovf_flag | ovf_evt;
            unf_flag   <= unf_flag | unf_evt;
        end
    end

    assign out_bit = data_q | ais_force;

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R12
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |=> unf_flag); // R12

endmodule

// File: tb/jitter_attenuator_bench.sv
module jitter_attenuator_bench;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned CLK_HZ = 19_440_000;
    localparam longint unsigned TWO32  = 64'd1 << 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_bit = 1'b0, rate_sel = 1'b0;
    logic        order_switch_en = 1'b0, ptr_adj = 1'b0, ais_force = 1'b0;
    logic [15:0] hold_len = '0;
    logic [3:0]  kp_shift = 4'd4, ki_shift = 4'd8;
    logic        out_strobe, out_bit, first_order, ovf_flag, unf_flag;
    logic [5:0]  fill_level;
    logic signed [31:0] loop_corr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    jitter_attenuator #(.CLK_HZ(CLK_HZ)) u_jitter_attenuator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .rate_sel(rate_sel), .order_switch_en(order_switch_en), .ptr_adj(ptr_adj),
        .hold_len(hold_len), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .ais_force(ais_force), .out_strobe(out_strobe), .out_bit(out_bit),
        .fill_level(fill_level), .loop_corr(loop_corr), .first_order(first_order),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int p_term(input int fill, input int kp);
        int e = fill - 16;
        return (e <<< 20) >>> kp;
    endfunction

    function automatic int i_term(input int fill, input int ki);
        int e = fill - 16;
        return (e <<< 14) >>> ki;
    endfunction

    function automatic longint unsigned nominal(input bit rate);
        longint unsigned bps = rate ? 64'd2048000 : 64'd1544000;
        return (bps << 32) / CLK_HZ;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; ptr_adj = 1'b0; ais_force = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit q[$];
        int got, prev_fill, run, exp_run, ref_i, iv;
        longint unsigned bacc, inc, pend, expk;
        void'($urandom(32'd61357));

        // R12: reset state, sampled while reset is held.
        rate_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(fill_level == 6'd16, "R12 reset fill", fill_level, 16);
        chk(out_strobe == 1'b0 && out_bit == 1'b1, "R12 reset strobe/bit", {out_strobe, out_bit}, 1);
        chk(loop_corr == 0 && first_order == 1'b0, "R12 reset corr/order", loop_corr, 0);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R12 reset flags", {ovf_flag, unf_flag}, 0);

        // R2: first strobe timing for each rate with zero correction.
        for (int r = 0; r < 2; r++) begin
            rate_sel = r[0];
            do_reset();
            inc = nominal(r[0]);
            expk = 1;
            while (expk * inc < TWO32) expk++;
            got = 0;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (out_strobe && got == 0) got = k;
            end
            chk(got == int'(expk), "R2 first strobe cycle", got, expk);
        end

        // R3/R4: proportional term while filling, integral step at first strobe.
        rate_sel = 1'b0;
        kp_shift = 4'($urandom_range(15, 6));
        ki_shift = 4'($urandom_range(15, 0));
        do_reset();
        in_valid = 1'b1; in_bit = 1'b1;
        prev_fill = 16; got = 0;
        for (int c = 1; c <= 20 && got == 0; c++) begin
            @(negedge clk);
            if (!out_strobe) begin
                chk(loop_corr == p_term(fill_level, kp_shift), "R3 proportional corr",
                    loop_corr, p_term(fill_level, kp_shift));
            end else begin
                chk(loop_corr - p_term(fill_level, kp_shift) == i_term(prev_fill, ki_shift),
                    "R4 integral step", loop_corr - p_term(fill_level, kp_shift),
                    i_term(prev_fill, ki_shift));
                got = 1;
            end
            prev_fill = fill_level;
            if (c == 12) in_valid = 1'b0;
        end
        chk(got == 1, "R4 strobe seen", got, 1);

        // R1, R5-R9: long random run with gapped input at the nominal rate.
        kp_shift = 4'($urandom_range(4, 2));
        ki_shift = 4'($urandom_range(10, 6));
        do_reset();
        q.delete();
        for (int i = 0; i < 16; i++) q.push_back(1'b1);
        inc = nominal(1'b0); bacc = 0; pend = 0;
        run = 0; exp_run = 0; ref_i = 0;
        for (int cyc = 0; cyc < 30000; cyc++) begin
            @(negedge clk);
            // samples from the previous edge
            if (out_strobe) begin
                got = (q.size() > 0) ? int'(q.pop_front()) : 1;
                if (ais_force) chk(out_bit == 1'b1, "R9 forced ones", out_bit, 1);
                else chk(out_bit == got[0], "R1 data order", out_bit, got);
            end
            if (first_order) begin
                run++;
                iv = loop_corr - p_term(fill_level, kp_shift);
                if (run == 1) ref_i = iv;
                else chk(iv == ref_i, "R8 integral frozen", iv, ref_i);
            end else if (run > 0) begin
                chk(run == exp_run, "R5/R6 window length", run, exp_run);
                run = 0;
            end
            if (cyc == 20003) chk(first_order == 1'b0, "R7 disabled event ignored", first_order, 0);
            if (cyc == 24003) chk(first_order == 1'b0, "R5 zero hold", first_order, 0);
            // drive for the next edge
            bacc += inc;
            if (bacc >= TWO32) begin bacc -= TWO32; pend++; end
            if (pend > 0 && ($urandom % 4) != 0) begin
                in_valid = 1'b1; in_bit = 1'($urandom % 2);
                q.push_back(in_bit); pend--;
            end else begin
                in_valid = 1'b0;
            end
            ais_force = (cyc >= 6000 && cyc < 9000);
            ptr_adj = 1'b0;
            case (cyc)
                12000: begin order_switch_en = 1'b1; hold_len = 16'd1500; exp_run = 1500; ptr_adj = 1'b1; end
                16000: begin hold_len = 16'd800; exp_run = 1100; ptr_adj = 1'b1; end
                16300: ptr_adj = 1'b1;  // R6 restart
                20000: begin order_switch_en = 1'b0; hold_len = 16'd500; ptr_adj = 1'b1; end
                24000: begin order_switch_en = 1'b1; hold_len = 16'd0; ptr_adj = 1'b1; end
                default: ;
            endcase
        end
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R1 no faults at nominal rate",
            {ovf_flag, unf_flag}, 0);

        // R11: stop writing until the store runs dry.
        in_valid = 1'b0; ptr_adj = 1'b0; ais_force = 1'b0;
        got = 0;
        for (int c = 0; c < 5000 && got == 0; c++) begin
            @(negedge clk);
            if (unf_flag) begin
                got = 1;
                chk(fill_level == 6'd16, "R11 recentre fill", fill_level, 16);
                chk(out_strobe && out_bit, "R11 ones on underflow", {out_strobe, out_bit}, 3);
            end
        end
        chk(got == 1, "R11 underflow seen", got, 1);
        in_valid = 1'b1;
        repeat (40) @(negedge clk);
        chk(unf_flag == 1'b1, "R12 underflow sticky", unf_flag, 1);

        // R10: write every cycle until the store overflows.
        kp_shift = 4'd15;
        do_reset();
        in_valid = 1'b1; in_bit = 1'b0;
        got = 0;
        for (int c = 0; c < 60 && got == 0; c++) begin
            @(negedge clk);
            if (ovf_flag) begin
                got = 1;
                chk(fill_level == 6'd16, "R10 recentre fill", fill_level, 16);
            end
        end
        chk(got == 1, "R10 overflow seen", got, 1);
        chk(unf_flag == 1'b0, "R12 reset cleared underflow", unf_flag, 0);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(ovf_flag == 1'b1, "R12 overflow sticky", ovf_flag, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule